// File: doc/BRIEF.md
# Host-to-DSP Word Receive Path

This block moves data from an 8-bit host bus into a 24-bit word that a DSP core consumes. The host writes up to three byte registers (high, middle, low) at fixed host addresses; the write to the low byte commits the word. The committed word then sits in a host-side buffer. Whenever the DSP-side receive register is free, the word moves on into it without any further action.

The host learns when it may write through an empty flag in its status register. It can also enable an active-low request pin that follows that flag. The DSP side is a valid/ready stream. `dsp_rx_valid` is the receive-full flag. A transfer happens on every clock edge where valid and ready are both high. While ready is low, the word and valid hold steady, so the DSP applies back-pressure by simply not reading. The host may write a fresh word only after that read: the empty flag comes back only when the DSP consumes the word. A DSP-side enable turns the receive-full flag into an interrupt request with a fixed vector. Two host-written semaphore bits are passed through to the DSP.

Top module: `host_rx_path`

## Requirements
- R1: After reset, the empty flag (host status register at address 2, bit 1) is 1, `dsp_rx_valid` is 0, the host control register at address 0 reads 0, `hreq_n` is 1 and `dsp_irq` is 0.
- R2: A host write to the low byte (address 7) clears the empty flag on the next edge. Writes to the high byte (address 5) or middle byte (address 6) alone change neither flag and commit nothing.
- R3: Byte registers the host did not write keep their previous contents, so a word committed after writing 3, 2 or 1 bytes carries the older high or middle bytes.
- R4: When the empty flag is 0 and `dsp_rx_valid` is 0, the buffered word is copied into `dsp_rx_data` and `dsp_rx_valid` rises on the following edge.
- R5: A DSP read (`dsp_rx_valid` and `dsp_rx_ready` both high at an edge) clears `dsp_rx_valid` and sets the empty flag. While valid is high and ready is low, `dsp_rx_data` and valid stay stable.
- R6: `hreq_n` is low exactly when host control bit 1 (transmit request enable) is 1 and the empty flag is 1. It is high within the cycle the flag clears.
- R7: `dsp_irq` is high when DSP control bit 0 (receive interrupt enable) and `dsp_rx_valid` are both 1. `dsp_irq_vec` then reads 0x20, and 0 otherwise.
- R8: The host control register at address 0 reads back the written value with bit 2 forced to 0. Its bits 3 and 4 appear on `dsp_host_flags[0]` and `dsp_host_flags[1]`.
- R9: If a low-byte write and a DSP read fall on the same edge, the write wins: the empty flag stays 0 and the new word reaches `dsp_rx_data` one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the address on host_addr |
| hreq_n | output | 1 | Active-low host request |
| dsp_hcr_we | input | 1 | DSP control register write strobe |
| dsp_hcr_wdata | input | 8 | DSP control register data, bit 0 = receive interrupt enable |
| dsp_rx_valid | output | 1 | Receive-full flag / stream valid |
| dsp_rx_ready | input | 1 | DSP consumes the word when high with valid |
| dsp_rx_data | output | 24 | Received word |
| dsp_irq | output | 1 | Receive interrupt request |
| dsp_irq_vec | output | 8 | Interrupt vector address while requesting |
| dsp_host_flags | output | 2 | Host semaphore bits as seen by the DSP |

## Verification
Two events can land on the same edge: a host low-byte write that commits a word, and a DSP read that frees the receive register. The bench first fills the receive register and stages a new high byte. It then drives the low-byte strobe and `dsp_rx_ready` in the same cycle. The result is judged at the ports. The empty flag must read 0 and valid must be 0 right after that edge, and the freshly assembled word must be presented one edge later.

// File: rtl/hrx_pkg.sv
package hrx_pkg;
  localparam int unsigned HOST_ADDR_W  = 3;
  localparam int unsigned HOST_BYTE_W  = 8;
  localparam int unsigned WORD_BYTES   = 3;
  localparam logic [HOST_ADDR_W-1:0] ADDR_CTRL   = 3'd0;
  localparam logic [HOST_ADDR_W-1:0] ADDR_STATUS = 3'd2;
  localparam logic [HOST_ADDR_W-1:0] ADDR_BYTE0  = 3'd5; // most significant byte
  localparam int unsigned CTRL_TREQ_BIT = 1;
  localparam int unsigned CTRL_RSVD_BIT = 2;
  localparam int unsigned CTRL_HF0_BIT  = 3;
  localparam int unsigned CTRL_HF1_BIT  = 4;
  localparam int unsigned STAT_EMPTY_BIT = 1;
  localparam logic [7:0]  RX_VECTOR     = 8'h20;
endpackage

// File: rtl/hrx_host_regs.sv
module hrx_host_regs
  import hrx_pkg::*;
#(
  parameter int unsigned ADDR_W = HOST_ADDR_W,
  parameter int unsigned BYTE_W = HOST_BYTE_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic              treq_en,
  output logic [1:0]        host_flags
);
  logic ctrl_wr;
  assign ctrl_wr = host_wr && (host_addr == ADDR_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= host_wdata;
      ctrl_q[CTRL_RSVD_BIT] <= 1'b0;
    end
  end

  assign treq_en    = ctrl_q[CTRL_TREQ_BIT];
  assign host_flags = {ctrl_q[CTRL_HF1_BIT], ctrl_q[CTRL_HF0_BIT]};
endmodule

// File: rtl/hrx_byte_buffer.sv
module hrx_byte_buffer
  import hrx_pkg::*;
#(
  parameter int unsigned ADDR_W  = HOST_ADDR_W,
  parameter int unsigned BYTE_W  = HOST_BYTE_W,
  parameter int unsigned N_BYTES = WORD_BYTES,
  localparam int unsigned WORD_W = BYTE_W * N_BYTES
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  input  logic              dsp_take,
  output logic [WORD_W-1:0] buf_word,
  output logic              empty_q,
  output logic              commit
);
  // byte i is at bit slice i; byte 0 is the least significant (committing) byte
  genvar gi;
  generate
    for (gi = 0; gi < N_BYTES; gi++) begin : g_byte
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(int'(ADDR_BYTE0) + N_BYTES - 1 - gi);
      logic [BYTE_W-1:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          byte_q <= '0;
        else if (host_wr && host_addr == MY_ADDR)
          byte_q <= host_wdata;
      end
      assign buf_word[gi*BYTE_W +: BYTE_W] = byte_q;
    end
  endgenerate

  localparam logic [ADDR_W-1:0] LOW_ADDR = ADDR_W'(int'(ADDR_BYTE0) + N_BYTES - 1);
  assign commit = host_wr && (host_addr == LOW_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      empty_q <= 1'b1;
    else if (commit)
      empty_q <= 1'b0;
    else if (dsp_take)
      empty_q <= 1'b1;
  end
endmodule

// File: rtl/hrx_word_stage.sv
module hrx_word_stage #(
  parameter int unsigned WORD_W = 24
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_empty,
  input  logic [WORD_W-1:0] buf_word,
  input  logic              dsp_ready,
  output logic              full_q,
  output logic [WORD_W-1:0] word_q,
  output logic              take
);
  logic move;
  assign move = !buf_empty && !full_q;
  assign take = full_q && dsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      word_q <= '0;
    end else if (move) begin
      full_q <= 1'b1;
      word_q <= buf_word;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/host_rx_path.sv
module host_rx_path
  import hrx_pkg::*;
#(
  parameter int unsigned ADDR_W  = HOST_ADDR_W,
  parameter int unsigned BYTE_W  = HOST_BYTE_W,
  parameter int unsigned N_BYTES = WORD_BYTES,
  parameter int unsigned VEC_W   = 8,
  localparam int unsigned WORD_W = BYTE_W * N_BYTES
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  output logic              hreq_n,
  input  logic              dsp_hcr_we,
  input  logic [BYTE_W-1:0] dsp_hcr_wdata,
  output logic              dsp_rx_valid,
  input  logic              dsp_rx_ready,
  output logic [WORD_W-1:0] dsp_rx_data,
  output logic              dsp_irq,
  output logic [VEC_W-1:0]  dsp_irq_vec,
  output logic [1:0]        dsp_host_flags
);
  logic [BYTE_W-1:0] ctrl_q;
  logic              treq_en;
  logic [WORD_W-1:0] buf_word;
  logic              empty_q;
  logic              commit;
  logic              take;
  logic              rx_ie_q;

  hrx_host_regs #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .ctrl_q(ctrl_q), .treq_en(treq_en),
    .host_flags(dsp_host_flags)
  );

  hrx_byte_buffer #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .dsp_take(take), .buf_word(buf_word),
    .empty_q(empty_q), .commit(commit)
  );

  hrx_word_stage #(.WORD_W(WORD_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .buf_empty(empty_q), .buf_word(buf_word),
    .dsp_ready(dsp_rx_ready), .full_q(dsp_rx_valid), .word_q(dsp_rx_data),
    .take(take)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rx_ie_q <= 1'b0;
    else if (dsp_hcr_we)
      rx_ie_q <= dsp_hcr_wdata[0];
  end

  assign hreq_n      = !(treq_en && empty_q);
  assign dsp_irq     = rx_ie_q && dsp_rx_valid;
  assign dsp_irq_vec = dsp_irq ? VEC_W'(RX_VECTOR) : '0;

  always_comb begin
    host_rdata = '0;
    if (host_addr == ADDR_CTRL)
      host_rdata = ctrl_q;
    else if (host_addr == ADDR_STATUS)
      host_rdata[STAT_EMPTY_BIT] = empty_q;
  end
endmodule

// File: rtl/host_rx_path_chk.sv
module host_rx_path_chk
  import hrx_pkg::*;
#(
  parameter int unsigned ADDR_W = HOST_ADDR_W,
  parameter int unsigned WORD_W = 24,
  parameter int unsigned VEC_W  = 8
)(
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic [ADDR_W-1:0] host_addr,
  input logic              empty,
  input logic              full,
  input logic              ready,
  input logic [WORD_W-1:0] data,
  input logic              hreq_n,
  input logic              irq,
  input logic [VEC_W-1:0]  irq_vec
);
  localparam logic [ADDR_W-1:0] LOW_A = ADDR_W'(int'(ADDR_BYTE0) + WORD_BYTES - 1);
  logic low_wr;
  assign low_wr = host_wr && host_addr == LOW_A;

  AST_LOW_WRITE_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    low_wr |=> !empty) else $error("low write"); // R2
  AST_UPPER_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr != LOW_A && empty && !full && !ready) |=> (empty && !full)) else $error("upper write"); // R2
  AST_AUTO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !full) |=> full) else $error("auto move"); // R4
  AST_READ_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (full && ready && !low_wr) |=> (!full && empty)) else $error("read"); // R5
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !ready) |=> (full && $stable(data))) else $error("hold"); // R5
  AST_HREQ_OFF_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !empty |-> hreq_n) else $error("hreq"); // R6
  AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (full && irq_vec == VEC_W'(RX_VECTOR))) else $error("irq"); // R7
  AST_COLLIDE_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && ready && low_wr) |=> (!empty && !full)) else $error("collide"); // R9
endmodule

bind host_rx_path host_rx_path_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
  .empty(empty_q), .full(dsp_rx_valid), .ready(dsp_rx_ready), .data(dsp_rx_data),
  .hreq_n(hreq_n), .irq(dsp_irq), .irq_vec(dsp_irq_vec)
);

// File: tb/test_host_rx_path.sv
`timescale 1ns/1ps
module test_host_rx_path;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [2:0]  host_addr = 3'd0;
  logic [7:0]  host_wdata = 8'd0;
  logic [7:0]  host_rdata;
  logic        hreq_n;
  logic        dsp_hcr_we = 1'b0;
  logic [7:0]  dsp_hcr_wdata = 8'd0;
  logic        dsp_rx_valid;
  logic        dsp_rx_ready = 1'b0;
  logic [23:0] dsp_rx_data;
  logic        dsp_irq;
  logic [7:0]  dsp_irq_vec;
  logic [1:0]  dsp_host_flags;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  host_rx_path i_host_rx_path (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .hreq_n(hreq_n),
    .dsp_hcr_we(dsp_hcr_we), .dsp_hcr_wdata(dsp_hcr_wdata),
    .dsp_rx_valid(dsp_rx_valid), .dsp_rx_ready(dsp_rx_ready),
    .dsp_rx_data(dsp_rx_data), .dsp_irq(dsp_irq), .dsp_irq_vec(dsp_irq_vec),
    .dsp_host_flags(dsp_host_flags)
  );

  // {mask[2:0] (high,mid,low), high, mid, low, expected word}
  localparam logic [50:0] VEC [6] = '{
    {3'b111, 8'h12, 8'h34, 8'h56, 24'h123456},
    {3'b011, 8'h00, 8'hAB, 8'hCD, 24'h12ABCD},
    {3'b001, 8'h00, 8'h00, 8'hEF, 24'h12ABEF},
    {3'b111, 8'hFF, 8'h00, 8'h01, 24'hFF0001},
    {3'b001, 8'h00, 8'h00, 8'h77, 24'hFF0077},
    {3'b011, 8'h00, 8'h80, 8'h00, 24'hFF8000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic dsp_read();
    @(negedge clk);
    dsp_rx_ready = 1'b1;
    @(negedge clk);
    dsp_rx_ready = 1'b0;
  endtask

  task automatic set_hcr(input logic [7:0] d);
    @(negedge clk);
    dsp_hcr_we = 1'b1; dsp_hcr_wdata = d;
    @(negedge clk);
    dsp_hcr_we = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    host_addr = a;
    #0.5;
    d = host_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    peek(3'd2, rd); check("R1 empty flag", 32'(rd[1]), 32'd1);
    peek(3'd0, rd); check("R1 ctrl reg", 32'(rd), 32'd0);
    check("R1 valid", 32'(dsp_rx_valid), 32'd0);
    check("R1 hreq_n", 32'(hreq_n), 32'd1);
    check("R1 irq", 32'(dsp_irq), 32'd0);

    host_write(3'd0, 8'h02);
    set_hcr(8'h01);
    @(negedge clk);
    check("R6 hreq when empty", 32'(hreq_n), 32'd0);

    // table walk: R3 R4 R5 R6 R7
    for (int i = 0; i < 6; i++) begin
      logic [50:0] v;
      v = VEC[i];
      if (v[50]) host_write(3'd5, v[47:40]);
      if (v[49]) host_write(3'd6, v[39:32]);
      host_write(3'd7, v[31:24]);
      peek(3'd2, rd); check("R2 low write clears empty", 32'(rd[1]), 32'd0);
      check("R6 hreq off", 32'(hreq_n), 32'd1);
      @(negedge clk);
      check("R4 valid after move", 32'(dsp_rx_valid), 32'd1);
      check("R3 assembled word", 32'(dsp_rx_data), 32'(v[23:0]));
      check("R7 irq", 32'(dsp_irq), 32'd1);
      check("R7 vector", 32'(dsp_irq_vec), 32'h20);
      @(negedge clk);
      check("R5 hold data", 32'(dsp_rx_data), 32'(v[23:0]));
      dsp_read();
      check("R5 valid cleared", 32'(dsp_rx_valid), 32'd0);
      peek(3'd2, rd); check("R5 empty set", 32'(rd[1]), 32'd1);
      check("R6 hreq back", 32'(hreq_n), 32'd0);
    end

    // R2 upper bytes alone do not commit
    host_write(3'd5, 8'h3C);
    host_write(3'd6, 8'h4D);
    @(negedge clk);
    check("R2 no commit valid", 32'(dsp_rx_valid), 32'd0);
    peek(3'd2, rd); check("R2 no commit empty", 32'(rd[1]), 32'd1);
    // R7 interrupt disabled
    set_hcr(8'h00);
    host_write(3'd7, 8'h5E);
    @(negedge clk);
    check("R2 commit after upper", 32'(dsp_rx_data), 32'h3C4D5E);
    check("R7 irq masked", 32'(dsp_irq), 32'd0);
    check("R7 vector idle", 32'(dsp_irq_vec), 32'd0);

    // R9 collision: receive register full, new high byte staged
    host_write(3'd5, 8'h11);
    @(negedge clk);
    host_wr = 1'b1; host_addr = 3'd7; host_wdata = 8'h22; dsp_rx_ready = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; dsp_rx_ready = 1'b0;
    check("R9 valid dropped", 32'(dsp_rx_valid), 32'd0);
    peek(3'd2, rd); check("R9 empty stays 0", 32'(rd[1]), 32'd0);
    @(negedge clk);
    check("R9 new word valid", 32'(dsp_rx_valid), 32'd1);
    check("R9 new word", 32'(dsp_rx_data), 32'h114D22);
    dsp_read();

    // R8 control register and semaphores
    host_write(3'd0, 8'h1A);
    peek(3'd0, rd); check("R8 ctrl readback", 32'(rd), 32'h1A);
    check("R8 flags", 32'(dsp_host_flags), 32'd3);
    host_write(3'd0, 8'h0C);
    peek(3'd0, rd); check("R8 reserved bit", 32'(rd), 32'h08);
    check("R8 flag0 only", 32'(dsp_host_flags), 32'd1);
    check("R6 hreq disabled", 32'(hreq_n), 32'd1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule